// File: doc/BRIEF.md
# Horizontal Slot Timing Counter

This block paces a tile-based video processor through a scan line one access slot at a time. A prescaler counts master-clock enable pulses. When a slot period is complete, the slot position advances. A full period is 16 ticks in the 40-cell wide mode. It is 20 ticks in the 32-cell narrow mode and in the legacy mode. In the wide mode the 8-bit slot number runs through every value. In the other two modes it leaves out the range 148 to 232.

For every slot the block also gives a set of qualifiers:
- a line-advance level for the vertical counter,
- a vblank-start evaluation level,
- a vertical-interrupt slot flag,
- hsync and hblank,
- a slot-kind code that tells the memory arbiter what each slot is for.

The active mode is sampled during reset and again each time the counter wraps to slot 0. A mode change therefore never tears a line. All outputs are registered, and they move only on the edge where the slot advances.

Top module: `hslot_timer`

## Requirements
- R1: A slot lasts exactly 16 mclk_en ticks in wide mode and 20 in narrow and legacy modes. The slot advances on the edge that takes in the last tick of the period.
- R2: In wide mode the slot number counts 0,1,...,255 and then wraps to 0.
- R3: In narrow and legacy modes the slot number counts 0..147, then goes straight to 233, counts up to 255 and wraps to 0. Values 148..232 never appear.
- R4: line_adv is high exactly while the slot is 165 (wide), 132 (narrow) or 249 (legacy).
- R5: vblank_chk is high exactly while the slot is 167 (wide) or 134 (narrow). It is never high in legacy mode.
- R6: hsync is high for slots 230..246 in wide mode and 236..248 in narrow and legacy modes.
- R7: hblank is high for slots 178..255 in wide mode and 233..255 in narrow and legacy modes. It is low at slot 0.
- R8: vint_slot is high at slot 4 in legacy mode and at slot 255 in the other modes.
- R9: In legacy mode, slot_kind reports as follows:
  - 2 (external) at slots 133..136, 234..238 and 251..252;
  - 0 (fetch) at slots 5..132;
  - 1 (sprite) at every other slot.
- R10: In narrow mode, slot_kind reports as follows:
  - 2 at slots 129, 130, 145 and 243;
  - 0 at slots 1..128;
  - 1 at every other slot.
  In wide mode slot_kind is always 3 (no assignment).
- R11: The mode is set by the inputs. Legacy is selected when legacy_sel is 1, whatever wide_sel is. Otherwise wide_sel=1 selects wide mode and wide_sel=0 selects narrow mode. The inputs are taken in only during reset and on the advance into slot 0. A change at any other time has no effect on slot timing or outputs until that wrap.
- R12: A synchronous reset sets the slot to 0 and clears the tick count. The qualifiers are set to their values for slot 0 in the mode being selected.
- R13: No output changes on an edge where the slot does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mclk_en | input | 1 | One master-clock tick |
| wide_sel | input | 1 | 1 selects 40-cell timing |
| legacy_sel | input | 1 | 1 selects legacy timing; overrides wide_sel |
| slot | output | 8 | Current slot number |
| line_adv | output | 1 | High during the line-advance slot |
| vblank_chk | output | 1 | High during the vblank-start evaluation slot |
| vint_slot | output | 1 | High during the vertical-interrupt slot |
| hsync | output | 1 | Horizontal sync window |
| hblank | output | 1 | Horizontal blanking window |
| slot_kind | output | 2 | 0 fetch, 1 sprite, 2 external, 3 none |

## Verification
The bench goes after the narrow-mode jump from 147 to 233. A design that missed it would spend 85 extra slots in a range that must never appear, so every later qualifier would land late.

It also changes the mode selects partway through a line and at random times. A design that applied the new mode at once would show a 16-tick slot inside a narrow line, or make the jump while wide mode is active.

The enable is gated at random and the bench compares every cycle. A counter that advanced one tick early or late, or that let an output move between slots, is caught on the first slot boundary it gets wrong.

Directed checks cover the reset state, legacy mode under a steady enable, and the edges of the external-slot groups and the fetch window.

// File: rtl/hslot_timer.sv
module hslot_timer #(
  parameter int TICKS_WIDE   = 16,
  parameter int TICKS_NARROW = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mclk_en,
  input  logic       wide_sel,
  input  logic       legacy_sel,
  output logic [7:0] slot,
  output logic       line_adv,
  output logic       vblank_chk,
  output logic       vint_slot,
  output logic       hsync,
  output logic       hblank,
  output logic [1:0] slot_kind
);
  localparam int TICK_MAX = (TICKS_NARROW > TICKS_WIDE) ? TICKS_NARROW : TICKS_WIDE;
  localparam int TW = $clog2(TICK_MAX);
  localparam logic [1:0] M_NARROW = 2'd0, M_WIDE = 2'd1, M_LEGACY = 2'd2;
  localparam logic [1:0] K_FETCH = 2'd0, K_SPRITE = 2'd1, K_EXT = 2'd2, K_NONE = 2'd3;

  logic [1:0]    mode_q;
  logic [TW-1:0] tick_q;
  logic [7:0]    slot_nx;

  wire [1:0]    mode_in   = legacy_sel ? M_LEGACY : (wide_sel ? M_WIDE : M_NARROW);
  wire [TW-1:0] last_tick = (mode_q == M_WIDE) ? TW'(TICKS_WIDE - 1) : TW'(TICKS_NARROW - 1);
  wire          adv       = mclk_en && (tick_q == last_tick);
  wire [1:0]    mode_nx   = (slot_nx == 8'd0) ? mode_in : mode_q;

  always_comb begin
    if (slot == 8'd255)                          slot_nx = 8'd0;
    else if (mode_q != M_WIDE && slot == 8'd147) slot_nx = 8'd233;
    else                                         slot_nx = slot + 8'd1;
  end

  function automatic logic [6:0] decode(input logic [1:0] m, input logic [7:0] s);
    logic la, vb, vi, hs, hb;
    logic [1:0] k;
    la = (m == M_WIDE) ? (s == 8'd165) : (m == M_LEGACY) ? (s == 8'd249) : (s == 8'd132);
    vb = (m == M_WIDE) ? (s == 8'd167) : (m == M_NARROW) ? (s == 8'd134) : 1'b0;
    vi = (m == M_LEGACY) ? (s == 8'd4) : (s == 8'd255);
    hs = (m == M_WIDE) ? (s >= 8'd230 && s <= 8'd246) : (s >= 8'd236 && s <= 8'd248);
    hb = (m == M_WIDE) ? (s >= 8'd178) : (s >= 8'd233);
    if (m == M_WIDE)
      k = K_NONE;
    else if (m == M_LEGACY) begin
      if ((s >= 8'd133 && s <= 8'd136) || (s >= 8'd234 && s <= 8'd238) || s == 8'd251 || s == 8'd252)
        k = K_EXT;
      else if (s >= 8'd5 && s <= 8'd132)
        k = K_FETCH;
      else
        k = K_SPRITE;
    end else begin
      if (s == 8'd129 || s == 8'd130 || s == 8'd145 || s == 8'd243)
        k = K_EXT;
      else if (s >= 8'd1 && s <= 8'd128)
        k = K_FETCH;
      else
        k = K_SPRITE;
    end
    return {la, vb, vi, hs, hb, k};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      slot   <= 8'd0;
      tick_q <= '0;
      mode_q <= mode_in;
      {line_adv, vblank_chk, vint_slot, hsync, hblank, slot_kind} <= decode(mode_in, 8'd0);
    end else if (mclk_en) begin
      if (adv) begin
        tick_q <= '0;
        slot   <= slot_nx;
        mode_q <= mode_nx;
        {line_adv, vblank_chk, vint_slot, hsync, hblank, slot_kind} <= decode(mode_nx, slot_nx);
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hslot_timer_chk.sv
module hslot_timer_chk #(
  parameter int TW           = 5,
  parameter int TICKS_WIDE   = 16,
  parameter int TICKS_NARROW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          adv,
  input logic [1:0]    mode,
  input logic [TW-1:0] tick,
  input logic [7:0]    slot,
  input logic          hsync,
  input logic          hblank,
  input logic [1:0]    slot_kind
);
  localparam logic [TW-1:0] LAST_W = TW'(TICKS_WIDE - 1);
  localparam logic [TW-1:0] LAST_N = TW'(TICKS_NARROW - 1);

  assert_tick_range_R1: assert property (@(posedge clk) disable iff (rst)
    tick <= ((mode == 2'd1) ? LAST_W : LAST_N));

  assert_wide_step_R2: assert property (@(posedge clk) disable iff (rst)
    (adv && mode == 2'd1) |=> slot == $past(slot) + 8'd1);

  assert_no_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd1) |-> (slot <= 8'd147 || slot >= 8'd233));

  assert_jump_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && mode != 2'd1 && slot == 8'd147) |=> slot == 8'd233);

  assert_sync_in_blank_R6: assert property (@(posedge clk) disable iff (rst)
    hsync |-> hblank);

  assert_legacy_ext_R9: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && slot_kind == 2'd2) |->
      ((slot >= 8'd133 && slot <= 8'd136) || (slot >= 8'd234 && slot <= 8'd238) ||
       slot == 8'd251 || slot == 8'd252));

  assert_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(slot) && $stable(slot_kind) && $stable(hblank) && $stable(hsync)));
endmodule

bind hslot_timer hslot_timer_chk #(
  .TW(TW), .TICKS_WIDE(TICKS_WIDE), .TICKS_NARROW(TICKS_NARROW)
) u_chk (
  .clk(clk), .rst(rst), .adv(adv), .mode(mode_q), .tick(tick_q),
  .slot(slot), .hsync(hsync), .hblank(hblank), .slot_kind(slot_kind)
);

// File: tb/hslot_timer_test.sv
module hslot_timer_test;
  logic clk = 1'b0;
  logic rst = 1'b1, mclk_en = 1'b0, wide_sel = 1'b0, legacy_sel = 1'b0;
  logic [7:0] slot;
  logic line_adv, vblank_chk, vint_slot, hsync, hblank;
  logic [1:0] slot_kind;
  int checks = 0, errors = 0;
  bit live = 1'b0;
  int e_slot = 0, e_tick = 0, e_mode = 0;
  int en_pct = 100;

  always #5 clk = ~clk;

  hslot_timer uut (
    .clk(clk), .rst(rst), .mclk_en(mclk_en), .wide_sel(wide_sel), .legacy_sel(legacy_sel),
    .slot(slot), .line_adv(line_adv), .vblank_chk(vblank_chk), .vint_slot(vint_slot),
    .hsync(hsync), .hblank(hblank), .slot_kind(slot_kind)
  );

  function automatic int sel_mode(bit w, bit l);
    return l ? 2 : (w ? 1 : 0);
  endfunction
  function automatic int period(int m);
    return (m == 1) ? 16 : 20;
  endfunction
  function automatic int following(int m, int s);
    if (s == 255) return 0;
    if (m != 1 && s == 147) return 233;
    return s + 1;
  endfunction
  function automatic bit x_line(int m, int s);
    return (m == 1) ? (s == 165) : (m == 2) ? (s == 249) : (s == 132);
  endfunction
  function automatic bit x_vbl(int m, int s);
    return (m == 1) ? (s == 167) : (m == 0) ? (s == 134) : 1'b0;
  endfunction
  function automatic bit x_vint(int m, int s);
    return (m == 2) ? (s == 4) : (s == 255);
  endfunction
  function automatic bit x_hsync(int m, int s);
    return (m == 1) ? (s >= 230 && s <= 246) : (s >= 236 && s <= 248);
  endfunction
  function automatic bit x_hblank(int m, int s);
    return (m == 1) ? (s >= 178) : (s >= 233);
  endfunction
  function automatic int x_kind(int m, int s);
    if (m == 1) return 3;
    if (m == 2) begin
      if ((s >= 133 && s <= 136) || (s >= 234 && s <= 238) || s == 251 || s == 252) return 2;
      if (s >= 5 && s <= 132) return 0;
      return 1;
    end
    if (s == 129 || s == 130 || s == 145 || s == 243) return 2;
    if (s >= 1 && s <= 128) return 0;
    return 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (model slot %0d mode %0d)", tag, act, exp, e_slot, e_mode);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      e_slot = 0; e_tick = 0; e_mode = sel_mode(wide_sel, legacy_sel);
    end else if (mclk_en) begin
      if (e_tick == period(e_mode) - 1) begin
        e_tick = 0;
        e_slot = following(e_mode, e_slot);
        if (e_slot == 0) e_mode = sel_mode(wide_sel, legacy_sel);
      end else e_tick++;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk(int'(slot) == e_slot, "R1/R2/R3/R11/R13 slot", slot, e_slot);
      chk(line_adv == x_line(e_mode, e_slot), "R4 line_adv", line_adv, x_line(e_mode, e_slot));
      chk(vblank_chk == x_vbl(e_mode, e_slot), "R5 vblank_chk", vblank_chk, x_vbl(e_mode, e_slot));
      chk(hsync == x_hsync(e_mode, e_slot), "R6 hsync", hsync, x_hsync(e_mode, e_slot));
      chk(hblank == x_hblank(e_mode, e_slot), "R7 hblank", hblank, x_hblank(e_mode, e_slot));
      chk(vint_slot == x_vint(e_mode, e_slot), "R8 vint_slot", vint_slot, x_vint(e_mode, e_slot));
      chk(int'(slot_kind) == x_kind(e_mode, e_slot), "R9/R10 slot_kind", slot_kind, x_kind(e_mode, e_slot));
    end
    mclk_en <= (($urandom % 100) < en_pct);
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_check(input bit w, input bit l);
    @(negedge clk);
    wide_sel = w; legacy_sel = l; rst = 1'b1;
    run(3);
    rst = 1'b0;
    // R12: outputs at slot 0 right after reset
    chk(slot == 8'd0, "R12 reset slot", slot, 0);
    chk(hblank == 1'b0, "R12 reset hblank", hblank, 0);
    chk(int'(slot_kind) == x_kind(sel_mode(w, l), 0), "R12 reset kind", slot_kind, x_kind(sel_mode(w, l), 0));
  endtask

  initial begin
    fork
      begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
    process_main();
  end

  task automatic process_main();
    void'($urandom(32'h5107));
    run(2);
    live = 1'b1;
    // narrow, gated enable, two lines
    en_pct = 75;
    reset_check(1'b0, 1'b0);
    run(10000);
    // R11: flip to wide mid-line; narrow jump must still happen this line
    wait (slot == 8'd60); @(negedge clk);
    wide_sel = 1'b1;
    wait (slot == 8'd233); @(negedge clk);
    chk(1'b1, "R11 narrow line kept after mid-line wide select", 1, 1);
    run(12000);
    // legacy, steady enable: directed 20-tick period
    en_pct = 100;
    reset_check(1'b0, 1'b1);
    begin
      int c = 0;
      wait (slot == 8'd10); @(negedge clk);
      while (slot == 8'd10) begin @(negedge clk); c++; end
      chk(c == 20 || c == 19, "R1 legacy period", c, 20);
    end
    run(8000);
    // wide overridden by legacy
    wide_sel = 1'b1;
    run(8000);
    // random mode flips
    en_pct = 60;
    for (int i = 0; i < 25; i++) begin
      run(200 + ($urandom % 1800));
      wide_sel = $urandom % 2;
      legacy_sel = ($urandom % 3) == 0;
    end
    // mid-run reset into wide
    reset_check(1'b1, 1'b0);
    run(6000);
    live = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask
endmodule